// File: doc/BRIEF.md
# Selectable-Tie Accumulator Rounder

This block takes a 40-bit multiply-accumulate result and rounds it to its upper 24 bits at the 16-bit boundary. The input splits into three fields: an 8-bit top field in bits 39:32, a 16-bit middle word in bits 31:16 and a 16-bit fraction word in bits 15:0. The result is the rounded upper 24 bits followed by a cleared fraction. Only the exact halfway fraction 0x8000 depends on the mode. In round-half-to-even mode a tie rounds up only when the middle word is odd. In always-up mode a tie always rounds up. Any other fraction rounds the same way in both modes.

The mode comes from bit 12 of a 16-bit control word, written through a simple write-enable port. The other bits of that word are kept in the register but do not change the rounding. A sample is offered with a valid strobe. One clock later the rounded value appears with its own valid flag and with a flag that marks a positive value that wrapped to negative.

Top module: `acc_rounder`

## Requirements
- R1: A fraction word (bits 15:0) greater than 0x8000 increments bits 39:16 by one in both modes.
- R2: A fraction word less than 0x8000 leaves bits 39:16 unchanged in both modes.
- R3: With control bit 12 at 0 (half-to-even mode), a fraction of exactly 0x8000 increments bits 39:16 only when bit 16 is 1. Otherwise bits 39:16 are unchanged.
- R4: With control bit 12 at 1 (always-up mode), a fraction of exactly 0x8000 always increments bits 39:16.
- R5: The mode is read only from bit 12 of the 16-bit control word. A control value with every other bit set and bit 12 clear rounds exactly like 0x0000.
- R6: A control write accepted at a clock edge applies to samples accepted from the next edge onward. A sample accepted at the same edge as the write uses the old mode.
- R7: The output fraction bits 15:0 are always zero. The increment carries from the middle word into the top field, and bits 39:16 wrap modulo 2^24.
- R8: The overflow flag is 1 exactly when the input bit 39 is 0 and the result bit 39 is 1. This happens only for 0x7FFFFF in bits 39:16 with an increment.
- R9: The output valid flag equals the input valid flag delayed by one clock. The rounded data and overflow flag appear in that same cycle and hold their values while no sample is accepted.
- R10: A synchronous reset clears the control word, which selects half-to-even mode, and clears the output valid flag, the output data and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrlWrEn | input | 1 | Control word write enable |
| ctrlWrData | input | 16 | Control word value; bit 12 selects always-up ties |
| inValid | input | 1 | Sample valid |
| inData | input | 40 | Accumulator value to round |
| outValid | output | 1 | Rounded result valid |
| outData | output | 40 | Rounded value with cleared fraction |
| outOverflow | output | 1 | Positive-to-negative wrap on the last rounding |

## Verification
Every rounded result, its overflow flag and its valid flag are due exactly one clock after the edge that accepts the sample. A control write is due to affect the sample accepted at the following edge. The bench drives inputs on falling edges and reads outputs on the next falling edge, which lands half a period after the single register stage. For the same-edge write-and-sample case, the first result is read at that point and the second one clock later. Hold behaviour is read one further falling edge after an idle cycle.

// File: rtl/rnd_pkg.sv
`timescale 1ns/1ps
package rnd_pkg;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capture;   // accept the present sample this edge
    logic biased;    // halfway ties round up unconditionally
  } rnd_strobe_t;

endpackage

// File: rtl/rnd_ctrl.sv
`timescale 1ns/1ps
module rnd_ctrl
  import rnd_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int MODE_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              inValid,
  output rnd_strobe_t       strb,
  output logic              outValid
);

  logic [CTRL_W-1:0] ctrlReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg  <= '0;
      outValid <= 1'b0;
    end else begin
      if (ctrlWrEn) ctrlReg <= ctrlWrData;
      outValid <= inValid;
    end
  end

  // Remaining fields are held for their owners elsewhere; rounding ignores them
  logic ctrlUnused;
  assign ctrlUnused = ^{ctrlReg[CTRL_W-1:MODE_BIT+1], ctrlReg[MODE_BIT-1:0]};

  assign strb.capture = inValid;
  assign strb.biased  = ctrlReg[MODE_BIT];

endmodule

// File: rtl/rnd_decide.sv
`timescale 1ns/1ps
module rnd_decide #(
  parameter int FRAC_W = 16
) (
  input  logic [FRAC_W-1:0] fracWord,
  input  logic              keepLsb,
  input  logic              biased,
  output logic              bumpUp
);

  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  logic aboveHalf;
  logic atHalf;

  always_comb begin
    aboveHalf = fracWord > HALF;
    atHalf    = fracWord == HALF;
    bumpUp    = aboveHalf | (atHalf & (biased | keepLsb));
  end

endmodule

// File: rtl/rnd_datapath.sv
`timescale 1ns/1ps
module rnd_datapath
  import rnd_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  rnd_strobe_t      strb,
  input  logic [ACC_W-1:0] inData,
  output logic [ACC_W-1:0] outData,
  output logic             outOverflow
);

  localparam int KEEP_W = ACC_W - FRAC_W;

  logic [KEEP_W-1:0] keepIn;
  logic [KEEP_W-1:0] keepSum;
  logic              bumpUp;
  logic              wrapPos;

  assign keepIn = inData[ACC_W-1:FRAC_W];

  rnd_decide #(.FRAC_W(FRAC_W)) decideInst (
    .fracWord (inData[FRAC_W-1:0]),
    .keepLsb  (keepIn[0]),
    .biased   (strb.biased),
    .bumpUp   (bumpUp)
  );

  always_comb begin
    keepSum = keepIn + KEEP_W'(bumpUp);
    wrapPos = ~keepIn[KEEP_W-1] & keepSum[KEEP_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData     <= '0;
      outOverflow <= 1'b0;
    end else if (strb.capture) begin
      outData     <= {keepSum, {FRAC_W{1'b0}}};
      outOverflow <= wrapPos;
    end
  end

endmodule

// File: rtl/acc_rounder.sv
`timescale 1ns/1ps
module acc_rounder
  import rnd_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int FRAC_W   = 16,
  parameter int CTRL_W   = 16,
  parameter int MODE_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              inValid,
  input  logic [ACC_W-1:0]  inData,
  output logic              outValid,
  output logic [ACC_W-1:0]  outData,
  output logic              outOverflow
);

  rnd_strobe_t strb;

  rnd_ctrl #(.CTRL_W(CTRL_W), .MODE_BIT(MODE_BIT)) ctrlInst (
    .clk        (clk),
    .rst        (rst),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .inValid    (inValid),
    .strb       (strb),
    .outValid   (outValid)
  );

  rnd_datapath #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) dpInst (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .inData      (inData),
    .outData     (outData),
    .outOverflow (outOverflow)
  );

endmodule

// File: rtl/rnd_chk.sv
`timescale 1ns/1ps
module rnd_chk #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [ACC_W-1:0] inData,
  input logic             biasNow,
  input logic             outValid,
  input logic [ACC_W-1:0] outData,
  input logic             outOverflow
);

  localparam int KEEP_W = ACC_W - FRAC_W;
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outData) && $stable(outOverflow)));
  // R7
  frac_clear_chk: assert property (@(posedge clk) disable iff (rst)
    outData[FRAC_W-1:0] == '0);
  // R1
  above_half_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(inData[FRAC_W-1:0]) > HALF) |->
      outData[ACC_W-1:FRAC_W] == KEEP_W'($past(inData[ACC_W-1:FRAC_W]) + 1'b1));
  // R2
  below_half_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(inData[FRAC_W-1:0]) < HALF) |->
      outData[ACC_W-1:FRAC_W] == $past(inData[ACC_W-1:FRAC_W]));
  // R4
  tie_biased_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(inData[FRAC_W-1:0]) == HALF && $past(biasNow)) |->
      outData[ACC_W-1:FRAC_W] == KEEP_W'($past(inData[ACC_W-1:FRAC_W]) + 1'b1));
  // R3
  tie_even_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(inData[FRAC_W-1:0]) == HALF && !$past(biasNow)) |->
      outData[FRAC_W] == 1'b0);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outOverflow == (!$past(inData[ACC_W-1]) && outData[ACC_W-1])));
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0 && !outOverflow));

endmodule

bind acc_rounder rnd_chk #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) chkInst (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .inData      (inData),
  .biasNow     (strb.biased),
  .outValid    (outValid),
  .outData     (outData),
  .outOverflow (outOverflow)
);

// File: tb/acc_rounder_test.sv
`timescale 1ns/1ps
module acc_rounder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic        inValid = 1'b0;
  logic [39:0] inData = '0;
  logic        outValid;
  logic [39:0] outData;
  logic        outOverflow;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  acc_rounder uut (
    .clk(clk), .rst(rst), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .inValid(inValid), .inData(inData), .outValid(outValid),
    .outData(outData), .outOverflow(outOverflow)
  );

  localparam int NV = 14;
  localparam logic [39:0] vIn [NV] = '{
    40'h00_0000_8000, 40'h00_0000_8000, 40'h00_0001_8000, 40'h00_0001_8000,
    40'h00_0000_8001, 40'h00_0000_8001, 40'h00_0001_7FFF, 40'h00_0001_7FFF,
    40'h7F_FFFF_8000, 40'hFF_FFFF_C000, 40'h12_3456_8000, 40'h00_FFFF_8000,
    40'h7F_FFFF_7FFF, 40'h80_0000_FFFF};
  localparam logic vBias [NV] = '{0,1,0,1,0,1,0,1,1,0,1,0,1,0};
  localparam logic [39:0] vExp [NV] = '{
    40'h00_0000_0000, 40'h00_0001_0000, 40'h00_0002_0000, 40'h00_0002_0000,
    40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0001_0000,
    40'h80_0000_0000, 40'h00_0000_0000, 40'h12_3457_0000, 40'h01_0000_0000,
    40'h7F_FFFF_0000, 40'h80_0001_0000};
  localparam logic vOvf [NV] = '{0,0,0,0,0,0,0,0,1,0,0,0,0,0};
  localparam string vTag [NV] = '{"R3","R4","R3","R4","R1","R1","R2","R2",
                                  "R8","R7","R4","R7","R8","R8"};

  task automatic check(input bit ok, input string tag,
                       input logic [39:0] act, input logic [39:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [15:0] w);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = w;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  // Present one sample; returns after the result edge, half a period later
  task automatic sendSample(input logic [39:0] d);
    @(negedge clk);
    inValid = 1'b1; inData = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(outValid == 1'b0, "R10 valid", {39'd0, outValid}, 40'd0);
    check(outData == '0, "R10 data", outData, 40'd0);
    check(outOverflow == 1'b0, "R10 ovf", {39'd0, outOverflow}, 40'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      writeCtrl(vBias[i] ? 16'h1000 : 16'h0000);
      sendSample(vIn[i]);
      check(outValid == 1'b1, {vTag[i], " R9 valid"}, {39'd0, outValid}, 40'd1);
      check(outData == vExp[i], vTag[i], outData, vExp[i]);
      check(outOverflow == vOvf[i], {vTag[i], " ovf"},
            {39'd0, outOverflow}, {39'd0, vOvf[i]});
    end

    // R9: hold while idle
    @(negedge clk);
    check(outValid == 1'b0, "R9 idle valid", {39'd0, outValid}, 40'd0);
    check(outData == 40'h80_0001_0000, "R9 hold", outData, 40'h80_0001_0000);

    // R5: every other control bit set, mode bit clear -> tie stays even
    writeCtrl(16'hEFFF);
    sendSample(40'h12_3456_8000);
    check(outData == 40'h12_3456_0000, "R5 other bits", outData, 40'h12_3456_0000);

    // R6: write and sample on one edge, then sample again
    writeCtrl(16'h0000);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = 16'h1000;
    inValid = 1'b1; inData = 40'h00_0000_8000;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    check(outData == 40'h00_0000_0000, "R6 same edge", outData, 40'h0);
    @(negedge clk);
    inValid = 1'b0;
    check(outData == 40'h00_0001_0000, "R6 next edge", outData, 40'h00_0001_0000);

    // R10: reset returns to half-to-even mode
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outData == '0, "R10 clear", outData, 40'h0);
    rst = 1'b0;
    sendSample(40'h00_0000_8000);
    check(outData == 40'h00_0000_0000, "R10 mode", outData, 40'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #1600000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog actual=%h expected=%h", 40'd0, 40'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule